// File: doc/BRIEF.md
# Flash Boot and Write-Enable Sequencer

This block orders multi-command operations on a serial flash. It sits above a command engine that does the serial framing. The engine takes one command at a time, given as an opcode, an address, a length, a write byte and a chip-select index. It returns any read bytes as a stream and then a completion pulse.

After reset the sequencer assumes the flash is write-protected and unlocks it. It copies a boot image from the device on chip select zero into a program-memory write port, and then lowers a host interrupt line to show that start-up is over. It then accepts program, sector-erase and chip-erase requests from the host. Each request is preceded by a write-enable handshake, and the sequencer waits for the flash to go idle before it reports completion.

Every status poll loop is bounded by a programmable limit. When the limit runs out, the operation ends with an error flag.

Top module: `flash_boot_seq`

## Requirements
- R1: After reset `host_irq` is 1. The first commands, all on chip select 0, are write enable (0x06), then read status (0x05) repeated until status bit 1 (enable latch) reads 1, then write status (0x01) with write byte 0x00.
- R2: After the write status command completes, exactly one fast read (0x0B) is issued, on chip select 0, at address `cfg_boot_addr` with length `cfg_boot_len`.
- R3: Each byte returned by the fast read is written to program memory one cycle after it arrives, at addresses 0, 1, 2 and so on in arrival order.
- R4: `host_irq` falls on the clock edge at which the fast read's completion is sampled, and it stays low until the next reset.
- R5: `hreq_ack` is never asserted while `host_irq` is 1. A request pulsed during start-up is dropped and issues no command.
- R6: An accepted request issues write enable on `hreq_cs`, then read status on `hreq_cs` until bit 1 reads 1, then the operation on `hreq_cs`. The kind encodings are 0 for page program (0x02, with address and length), 1 for sector erase (0x20, with address) and 2 or 3 for chip erase (0xC7).
- R7: After the operation, read status is repeated until bit 0 (busy) reads 0. `hreq_done` then pulses for one cycle with `hreq_err` at 0.
- R8: A poll loop issues at most `cfg_poll_limit` reads (the limit must be at least 1). If the awaited bit has not appeared by then, `hreq_err` becomes 1 and no further command is issued. For a host request `hreq_done` pulses. At start-up, `host_irq` falls and the fast read is skipped.
- R9: Write disable (0x04) is never issued. `eng_req` is a single-cycle pulse and is not raised again until `eng_done` has been seen.
- R10: `hreq_err` is cleared when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_boot_addr | input | FAW | Flash address of the boot image |
| cfg_boot_len | input | LENW | Boot image length in bytes |
| cfg_poll_limit | input | PCW | Maximum status reads per poll loop |
| hreq_valid | input | 1 | Host request present |
| hreq_kind | input | 2 | 0 program, 1 sector erase, 2/3 chip erase |
| hreq_addr | input | FAW | Flash address of the request |
| hreq_len | input | LENW | Program length in bytes |
| hreq_cs | input | 1 | Chip select used by the request |
| hreq_ack | output | 1 | One-cycle pulse when a request is taken |
| hreq_done | output | 1 | One-cycle pulse when a request ends |
| hreq_err | output | 1 | Poll limit ran out in the last operation |
| host_irq | output | 1 | High while start-up runs |
| eng_req | output | 1 | One-cycle command strobe to the engine |
| eng_op | output | 8 | Command opcode |
| eng_addr | output | FAW | Command address |
| eng_len | output | LENW | Command data length |
| eng_wbyte | output | 8 | Byte for write status |
| eng_cs | output | 1 | Chip-select index |
| eng_rx_valid | input | 1 | Read byte strobe from the engine |
| eng_rx_data | input | 8 | Read byte |
| eng_done | input | 1 | Command completion pulse |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | PMAW | Program memory write address |
| pm_wdata | output | 8 | Program memory write data |

## Verification
On every cycle the assertions check several properties. The interrupt line never rises again once it is low. Requests are never taken during start-up. The boot read always uses chip select zero. Write disable is never issued and command strobes are single pulses. Every operation command follows a status read with the enable latch set, and a clean completion follows a status read with busy clear. Program-memory writes land at consecutive addresses, and no poll loop exceeds its limit.

Only the bench's scenarios can show the following. The exact command order and poll counts for different latch and busy delays. The copied image contents against the flash address. The error paths in both the latch and the busy loops, and at start-up. The clearing of the error flag by the next request.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h0B;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SERASE = 8'h20;
  localparam logic [7:0] OP_CERASE = 8'hC7;

  localparam int ST_BIT_BUSY  = 0;
  localparam int ST_BIT_LATCH = 1;

  typedef enum logic [3:0] {
    S_WREN, S_WREN_W, S_LPOLL, S_LPOLL_W, S_WRSR, S_WRSR_W,
    S_READ, S_READ_W, S_IDLE, S_OP, S_OP_W, S_BPOLL, S_BPOLL_W
  } seq_state_t;
endpackage

// File: rtl/fbs_poll_ctr.sv
module fbs_poll_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          spent
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign spent = (cnt >= limit);

  // R8: a poll is never issued once the budget is used up
  p_poll_budget_r8: assert property (@(posedge clk) disable iff (rst)
    inc |-> !spent) else $error("poll issued past limit");
endmodule

// File: rtl/fbs_copy_ctr.sv
module fbs_copy_ctr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          pm_we,
  output logic [AW-1:0] pm_addr,
  output logic [7:0]    pm_wdata
);
  logic [AW-1:0] nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_we    <= 1'b0;
      pm_addr  <= '0;
      pm_wdata <= '0;
      nxt      <= '0;
    end else begin
      pm_we <= en && rx_valid;
      if (en && rx_valid) begin
        pm_addr  <= nxt;
        pm_wdata <= rx_data;
        nxt      <= nxt + 1'b1;
      end
    end
  end

  logic [AW-1:0] seen;
  always_ff @(posedge clk) begin
    if (rst)        seen <= '0;
    else if (pm_we) seen <= seen + 1'b1;
  end

  // R3: writes go to consecutive addresses starting at zero
  p_pm_consecutive_r3: assert property (@(posedge clk) disable iff (rst)
    pm_we |-> pm_addr == seen) else $error("program memory address skipped");
endmodule

// File: rtl/flash_boot_seq.sv
module flash_boot_seq
  import fbs_pkg::*;
#(
  parameter int FAW  = 24,
  parameter int LENW = 16,
  parameter int PCW  = 16,
  parameter int PMAW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [FAW-1:0]  cfg_boot_addr,
  input  logic [LENW-1:0] cfg_boot_len,
  input  logic [PCW-1:0]  cfg_poll_limit,
  input  logic            hreq_valid,
  input  logic [1:0]      hreq_kind,
  input  logic [FAW-1:0]  hreq_addr,
  input  logic [LENW-1:0] hreq_len,
  input  logic            hreq_cs,
  output logic            hreq_ack,
  output logic            hreq_done,
  output logic            hreq_err,
  output logic            host_irq,
  output logic            eng_req,
  output logic [7:0]      eng_op,
  output logic [FAW-1:0]  eng_addr,
  output logic [LENW-1:0] eng_len,
  output logic [7:0]      eng_wbyte,
  output logic            eng_cs,
  input  logic            eng_rx_valid,
  input  logic [7:0]      eng_rx_data,
  input  logic            eng_done,
  output logic            pm_we,
  output logic [PMAW-1:0] pm_addr,
  output logic [7:0]      pm_wdata
);
  seq_state_t      state;
  logic            in_boot;
  logic [7:0]      stat_q;
  logic [1:0]      k_q;
  logic [FAW-1:0]  a_q;
  logic [LENW-1:0] l_q;
  logic            cs_q;
  logic            poll_clr, poll_inc, spent;

  assign poll_clr = eng_done && (state == S_WREN_W || state == S_OP_W);
  assign poll_inc = (state == S_LPOLL) || (state == S_BPOLL);

  fbs_poll_ctr #(.CW(PCW)) u_poll (
    .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc),
    .limit(cfg_poll_limit), .spent(spent)
  );

  fbs_copy_ctr #(.AW(PMAW)) u_copy (
    .clk(clk), .rst(rst), .en(state == S_READ_W),
    .rx_valid(eng_rx_valid), .rx_data(eng_rx_data),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst)               stat_q <= '0;
    else if (eng_rx_valid) stat_q <= eng_rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_WREN;
      in_boot   <= 1'b1;
      host_irq  <= 1'b1;
      hreq_ack  <= 1'b0;
      hreq_done <= 1'b0;
      hreq_err  <= 1'b0;
      eng_req   <= 1'b0;
      eng_op    <= '0;
      eng_addr  <= '0;
      eng_len   <= '0;
      eng_wbyte <= '0;
      eng_cs    <= 1'b0;
      k_q       <= '0;
      a_q       <= '0;
      l_q       <= '0;
      cs_q      <= 1'b0;
    end else begin
      eng_req   <= 1'b0;
      hreq_ack  <= 1'b0;
      hreq_done <= 1'b0;
      case (state)
        S_WREN, S_LPOLL, S_BPOLL: begin
          eng_req   <= 1'b1;
          eng_op    <= (state == S_WREN) ? OP_WREN : OP_RDSR;
          eng_addr  <= '0;
          eng_len   <= '0;
          eng_wbyte <= '0;
          eng_cs    <= in_boot ? 1'b0 : cs_q;
          state     <= (state == S_WREN) ? S_WREN_W :
                       (state == S_LPOLL) ? S_LPOLL_W : S_BPOLL_W;
        end
        S_WREN_W: if (eng_done) state <= S_LPOLL;
        S_LPOLL_W: if (eng_done) begin
          if (stat_q[ST_BIT_LATCH]) state <= in_boot ? S_WRSR : S_OP;
          else if (spent) begin
            hreq_err <= 1'b1;
            state    <= S_IDLE;
            if (in_boot) begin
              in_boot  <= 1'b0;
              host_irq <= 1'b0;
            end else hreq_done <= 1'b1;
          end else state <= S_LPOLL;
        end
        S_WRSR: begin
          eng_req   <= 1'b1;
          eng_op    <= OP_WRSR;
          eng_wbyte <= 8'h00;
          eng_cs    <= 1'b0;
          state     <= S_WRSR_W;
        end
        S_WRSR_W: if (eng_done) state <= S_READ;
        S_READ: begin
          eng_req  <= 1'b1;
          eng_op   <= OP_READ;
          eng_addr <= cfg_boot_addr;
          eng_len  <= cfg_boot_len;
          eng_cs   <= 1'b0;
          state    <= S_READ_W;
        end
        S_READ_W: if (eng_done) begin
          in_boot  <= 1'b0;
          host_irq <= 1'b0;
          state    <= S_IDLE;
        end
        S_IDLE: if (hreq_valid) begin
          hreq_ack <= 1'b1;
          hreq_err <= 1'b0;
          k_q      <= hreq_kind;
          a_q      <= hreq_addr;
          l_q      <= hreq_len;
          cs_q     <= hreq_cs;
          state    <= S_WREN;
        end
        S_OP: begin
          eng_req   <= 1'b1;
          eng_cs    <= cs_q;
          eng_wbyte <= '0;
          case (k_q)
            2'd0: begin eng_op <= OP_PROG;   eng_addr <= a_q; eng_len <= l_q; end
            2'd1: begin eng_op <= OP_SERASE; eng_addr <= a_q; eng_len <= '0;  end
            default: begin eng_op <= OP_CERASE; eng_addr <= '0; eng_len <= '0; end
          endcase
          state <= S_OP_W;
        end
        S_OP_W: if (eng_done) state <= S_BPOLL;
        S_BPOLL_W: if (eng_done) begin
          if (!stat_q[ST_BIT_BUSY]) begin
            hreq_done <= 1'b1;
            state     <= S_IDLE;
          end else if (spent) begin
            hreq_err  <= 1'b1;
            hreq_done <= 1'b1;
            state     <= S_IDLE;
          end else state <= S_BPOLL;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4: once start-up has ended the interrupt stays low
  p_irq_stays_low_r4: assert property (@(posedge clk) disable iff (rst)
    !host_irq |=> !host_irq) else $error("host_irq rose again");
  // R5: no request is taken while start-up runs
  p_no_ack_in_boot_r5: assert property (@(posedge clk) disable iff (rst)
    hreq_ack |-> !host_irq) else $error("request taken during start-up");
  // R2: the boot image comes from chip select zero
  p_boot_cs0_r2: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_op == OP_READ) |-> !eng_cs) else $error("boot read off cs0");
  // R9: no write-disable command, strobes are single pulses
  p_no_wrdi_r9: assert property (@(posedge clk) disable iff (rst)
    eng_req |-> eng_op != 8'h04) else $error("write disable issued");
  p_single_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    eng_req |=> !eng_req) else $error("command strobe held");
  // R6: every write-class command follows a status read with latch set
  p_latch_before_write_r6: assert property (@(posedge clk) disable iff (rst)
    (eng_req && (eng_op == OP_PROG || eng_op == OP_SERASE ||
                 eng_op == OP_CERASE || eng_op == OP_WRSR)) |-> stat_q[ST_BIT_LATCH])
    else $error("write command without enable latch");
  // R7: a clean completion follows a status read with busy clear
  p_idle_before_done_r7: assert property (@(posedge clk) disable iff (rst)
    (hreq_done && !hreq_err) |-> !stat_q[ST_BIT_BUSY])
    else $error("done while flash busy");
endmodule

// File: tb/flash_boot_seq_test.sv
module flash_boot_seq_test;
  localparam int FAW = 24, LENW = 16, PCW = 16, PMAW = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic [FAW-1:0]  cfg_boot_addr = 24'h001230;
  logic [LENW-1:0] cfg_boot_len  = 16'd20;
  logic [PCW-1:0]  cfg_poll_limit = 16'd8;
  logic hreq_valid = 1'b0, hreq_cs = 1'b0;
  logic [1:0] hreq_kind = 2'd0;
  logic [FAW-1:0] hreq_addr = '0;
  logic [LENW-1:0] hreq_len = '0;
  logic hreq_ack, hreq_done, hreq_err, host_irq;
  logic eng_req, eng_cs, pm_we;
  logic [7:0] eng_op, eng_wbyte, pm_wdata;
  logic [FAW-1:0] eng_addr;
  logic [LENW-1:0] eng_len;
  logic eng_rx_valid = 1'b0, eng_done = 1'b0;
  logic [7:0] eng_rx_data = 8'h00;
  logic [PMAW-1:0] pm_addr;

  always #10 clk = ~clk;

  flash_boot_seq #(.FAW(FAW), .LENW(LENW), .PCW(PCW), .PMAW(PMAW)) uut (
    .clk(clk), .rst(rst), .cfg_boot_addr(cfg_boot_addr), .cfg_boot_len(cfg_boot_len),
    .cfg_poll_limit(cfg_poll_limit), .hreq_valid(hreq_valid), .hreq_kind(hreq_kind),
    .hreq_addr(hreq_addr), .hreq_len(hreq_len), .hreq_cs(hreq_cs), .hreq_ack(hreq_ack),
    .hreq_done(hreq_done), .hreq_err(hreq_err), .host_irq(host_irq), .eng_req(eng_req),
    .eng_op(eng_op), .eng_addr(eng_addr), .eng_len(eng_len), .eng_wbyte(eng_wbyte),
    .eng_cs(eng_cs), .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
    .eng_done(eng_done), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata));

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] img(input logic [FAW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // behavioural flash + engine model
  logic [7:0] q_op[$];
  logic [FAW-1:0] q_addr[$];
  int q_len[$];
  logic [7:0] q_wb[$];
  logic q_cs[$];
  bit wel_pend = 0, wel_never = 0, boot_rd = 0;
  int wel_left = 0, wel_delay = 2, busy_left = 0, busy_polls = 2;

  initial forever begin
    @(negedge clk);
    if (!rst && eng_req) begin
      q_op.push_back(eng_op); q_addr.push_back(eng_addr);
      q_len.push_back(int'(eng_len)); q_wb.push_back(eng_wbyte); q_cs.push_back(eng_cs);
      repeat (2) @(negedge clk);
      case (eng_op)
        8'h06: begin wel_pend = 1; wel_left = wel_delay; end
        8'h05: begin
          eng_rx_data = {6'b0, wel_pend && wel_left == 0 && !wel_never, busy_left > 0};
          if (busy_left > 0) busy_left--;
          if (wel_pend && wel_left > 0) wel_left--;
          eng_rx_valid = 1; @(negedge clk); eng_rx_valid = 0;
        end
        8'h01: wel_pend = 0;
        8'h0B: begin
          boot_rd = 1;
          for (int i = 0; i < int'(eng_len); i++) begin
            eng_rx_data = img(eng_addr + FAW'(i));
            eng_rx_valid = 1; @(negedge clk); eng_rx_valid = 0;
            if (i % 3 == 1) @(negedge clk);
          end
        end
        default: begin wel_pend = 0; busy_left = busy_polls; end
      endcase
      eng_done = 1; @(negedge clk); eng_done = 0;
    end
  end

  // cycle-level reference for the interrupt line and program memory writes
  bit exp_irq = 1, irq_model_on = 1;
  int pm_cnt = 0;
  always @(posedge clk) begin
    if (rst) exp_irq = 1;
    else if (eng_done && boot_rd) exp_irq = 0;
  end
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (irq_model_on) chk(host_irq == exp_irq, "R4", "irq per cycle", host_irq, exp_irq);
      chk(!(hreq_ack && host_irq), "R5", "ack during start-up", hreq_ack, 0);
      if (pm_we) begin
        chk(pm_addr == PMAW'(pm_cnt), "R3", "pm address", pm_addr, pm_cnt);
        chk(pm_wdata == img(cfg_boot_addr + FAW'(pm_cnt)), "R3", "pm data",
            pm_wdata, img(cfg_boot_addr + FAW'(pm_cnt)));
        pm_cnt++;
      end
    end
  end

  task automatic exp_cmd(input int idx, input logic [7:0] op, input logic cs, input string req);
    if (idx >= q_op.size()) begin
      chk(0, req, "missing command", q_op.size(), idx + 1);
    end else begin
      chk(q_op[idx] == op, req, "opcode", q_op[idx], op);
      chk(q_cs[idx] == cs, req, "chip select", q_cs[idx], cs);
    end
  endtask

  task automatic exp_polls(input int base, input int n, input logic cs, input string req);
    for (int i = 0; i < n; i++) exp_cmd(base + i, 8'h05, cs, req);
  endtask

  task automatic host_op(input logic [1:0] kind, input logic [FAW-1:0] a,
                         input int len, input logic cs, output bit err);
    int n;
    @(negedge clk);
    hreq_kind = kind; hreq_addr = a; hreq_len = LENW'(len); hreq_cs = cs; hreq_valid = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!hreq_ack && n < 100);
    hreq_valid = 0;
    n = 0;
    while (!hreq_done && n < 2000) begin @(negedge clk); n++; end
    err = hreq_err;
    chk(hreq_done, "R7", "done pulse seen", hreq_done, 1);
  endtask

  initial begin
    int base, n;
    bit e;
    repeat (5) @(negedge clk);
    chk(host_irq == 1, "R1", "irq during reset", host_irq, 1);
    chk(pm_we == 0, "R1", "no pm write in reset", pm_we, 0);
    rst = 0;
    @(negedge clk);
    chk(host_irq == 1, "R1", "irq after reset", host_irq, 1);
    chk(hreq_err == 0, "R1", "err after reset", hreq_err, 0);
    // R5: pulse a request during start-up
    repeat (3) @(negedge clk);
    hreq_valid = 1; hreq_kind = 2'd0; hreq_addr = 24'h000100; hreq_len = 16'd4;
    repeat (5) @(negedge clk);
    hreq_valid = 0;
    n = 0;
    while (host_irq && n < 2000) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
    chk(q_op.size() == 6, "R5", "commands after boot", q_op.size(), 6);
    exp_cmd(0, 8'h06, 0, "R1");
    exp_polls(1, 3, 0, "R1");
    exp_cmd(4, 8'h01, 0, "R1");
    chk(q_wb[4] == 8'h00, "R1", "write status byte", q_wb[4], 0);
    exp_cmd(5, 8'h0B, 0, "R2");
    chk(q_addr[5] == cfg_boot_addr, "R2", "boot address", q_addr[5], cfg_boot_addr);
    chk(q_len[5] == 20, "R2", "boot length", q_len[5], 20);
    chk(pm_cnt == 20, "R3", "bytes copied", pm_cnt, 20);
    chk(host_irq == 0, "R4", "irq low after boot", host_irq, 0);

    // R6/R7: page program on cs1, latch immediate
    wel_delay = 0; busy_polls = 2; base = q_op.size();
    host_op(2'd0, 24'h004400, 64, 1, e);
    chk(q_op.size() == base + 6, "R6", "program command count", q_op.size(), base + 6);
    exp_cmd(base, 8'h06, 1, "R6");
    exp_cmd(base + 1, 8'h05, 1, "R6");
    exp_cmd(base + 2, 8'h02, 1, "R6");
    chk(q_addr[base + 2] == 24'h004400, "R6", "program address", q_addr[base + 2], 24'h004400);
    chk(q_len[base + 2] == 64, "R6", "program length", q_len[base + 2], 64);
    exp_polls(base + 3, 3, 1, "R7");
    chk(e == 0, "R7", "program err", e, 0);

    // sector erase on cs0, latch after one extra poll
    wel_delay = 1; busy_polls = 2; base = q_op.size();
    host_op(2'd1, 24'h003000, 0, 0, e);
    chk(q_op.size() == base + 7, "R6", "erase command count", q_op.size(), base + 7);
    exp_cmd(base, 8'h06, 0, "R6");
    exp_polls(base + 1, 2, 0, "R6");
    exp_cmd(base + 3, 8'h20, 0, "R6");
    chk(q_addr[base + 3] == 24'h003000, "R6", "erase address", q_addr[base + 3], 24'h003000);
    exp_polls(base + 4, 3, 0, "R7");
    chk(e == 0, "R7", "erase err", e, 0);

    // chip erase, flash idle at first busy poll
    wel_delay = 0; busy_polls = 0; base = q_op.size();
    host_op(2'd2, 24'h0, 0, 1, e);
    chk(q_op.size() == base + 4, "R7", "chip erase count", q_op.size(), base + 4);
    exp_cmd(base + 2, 8'h C7, 1, "R6");
    exp_cmd(base + 3, 8'h05, 1, "R7");

    // R8: latch never appears
    wel_never = 1; cfg_poll_limit = 16'd4; base = q_op.size();
    host_op(2'd1, 24'h001000, 0, 0, e);
    chk(e == 1, "R8", "latch timeout err", e, 1);
    repeat (10) @(negedge clk);
    chk(q_op.size() == base + 5, "R8", "latch timeout commands", q_op.size(), base + 5);
    exp_polls(base + 1, 4, 0, "R8");

    // R10: next accepted request clears err
    wel_never = 0; cfg_poll_limit = 16'd3; busy_polls = 10; base = q_op.size();
    @(negedge clk);
    hreq_kind = 2'd0; hreq_addr = 24'h000200; hreq_len = 16'd8; hreq_cs = 0; hreq_valid = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!hreq_ack && n < 100);
    hreq_valid = 0;
    @(negedge clk);
    chk(hreq_err == 0, "R10", "err cleared on accept", hreq_err, 0);
    n = 0;
    while (!hreq_done && n < 2000) begin @(negedge clk); n++; end
    chk(hreq_err == 1, "R8", "busy timeout err", hreq_err, 1);
    repeat (10) @(negedge clk);
    chk(q_op.size() == base + 6, "R8", "busy timeout commands", q_op.size(), base + 6);
    exp_polls(base + 3, 3, 0, "R8");

    // R9: no write disable anywhere in the log
    n = 0;
    foreach (q_op[i]) if (q_op[i] == 8'h04) n++;
    chk(n == 0, "R9", "write disable count", n, 0);

    // R8 at start-up: second reset with a latch that never sets
    irq_model_on = 0; wel_never = 1; cfg_poll_limit = 16'd3; busy_left = 0;
    rst = 1; repeat (3) @(negedge clk);
    q_op.delete(); q_addr.delete(); q_len.delete(); q_wb.delete(); q_cs.delete();
    pm_cnt = 0; boot_rd = 0; wel_pend = 0;
    rst = 0;
    n = 0;
    while (host_irq && n < 2000) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
    chk(host_irq == 0, "R8", "irq low after boot timeout", host_irq, 0);
    chk(hreq_err == 1, "R8", "boot timeout err", hreq_err, 1);
    chk(q_op.size() == 4, "R8", "boot timeout commands", q_op.size(), 4);
    exp_polls(1, 3, 0, "R8");
    chk(pm_cnt == 0, "R8", "no copy after timeout", pm_cnt, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule